// File: doc/BRIEF.md
# General-Register Datapath with Control Word

This block is the execution datapath of a small processor. It holds seven 8-bit general registers and one shared ALU. A 14-bit control word arrives every clock cycle. Its fields pick the register or external word for each of the two ALU operand buses, the operation, and the register that receives the result on the next rising edge. Instruction fetch, sequencing and memory sit outside the block. The control word comes straight from whatever drives the block.

The ALU result is always driven on the output port as combinational logic, whatever register is or is not written. Register code zero has a special meaning. As a source it selects the external input word. As a destination it selects nothing, so the result goes out of the block without being stored. Four status flags (carry, sign, zero, overflow) are held in a register and follow the class of the operation just executed.

Top module: `gr_datapath`

## Requirements
- R1: The control word bits are [13:11] A-source select, [10:8] B-source select, [7:5] destination select and [4:0] operation code.
- R2: Source select codes 1 to 7 put register R1 to R7 on that operand bus. Code 0 puts `ext_i` on it. Each bus selects on its own.
- R3: A destination code of 1 to 7 loads the ALU result into that register on the rising clock edge. Every other register keeps its value.
- R4: A destination code of 0 writes no register. The result is still driven on `result_o`.
- R5: `result_o` reflects the current control word and register contents in the same cycle, before the edge that stores it.
- R6: Arithmetic codes: 00001 gives A+1, 00010 gives A+B, 00101 gives A+~B+1, 00110 gives A-1. All results are taken modulo 256.
- R7: Logic codes: 00000 gives A, 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, 01110 gives NOT A.
- R8: Code 10000 shifts A right by one. Code 11000 shifts A left by one. Both fill with zero.
- R9: Any other operation code gives a result of zero and leaves the flags unchanged.
- R10: After an arithmetic operation, `flags_o` = {C,S,Z,V} (bit 3 to bit 0). C is the carry out of bit 7. S is result bit 7. Z is set when the result is zero. V is the carry into bit 7 XOR the carry out of bit 7.
- R11: After a logic, transfer or shift operation, S and Z follow the result, and C and V are cleared.
- R12: A synchronous active-high `rst` clears all registers and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 14 | Control word for this cycle |
| ext_i | input | 8 | External data word, used by source code 0 |
| result_o | output | 8 | ALU result for the current control word |
| flags_o | output | 4 | Registered flags {C,S,Z,V} |

## Verification
The hardest point to reach is flag behaviour that depends on history. A logic operation must be seen clearing C and V that an earlier arithmetic operation had set. An unused opcode must be seen holding flags that are nonzero. The stimulus therefore places those operations directly after increments and overflowing additions that leave C or V at one. It also loads registers with values chosen so that overflow, borrow and zero results occur. Writes with destination code 0 are followed by reads of the same register to show that nothing was stored.

// File: rtl/gr_pkg.sv
package gr_pkg;

    localparam int SEL_W = 3;
    localparam int OP_W  = 5;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 5'b00000,
        OP_INC  = 5'b00001,
        OP_ADD  = 5'b00010,
        OP_SUB  = 5'b00101,
        OP_DEC  = 5'b00110,
        OP_AND  = 5'b01000,
        OP_OR   = 5'b01010,
        OP_XOR  = 5'b01100,
        OP_NOT  = 5'b01110,
        OP_SHR  = 5'b10000,
        OP_SHL  = 5'b11000
    } gr_op_e;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_ARITH,
        CLS_LOGIC
    } gr_cls_e;

    typedef struct packed {
        logic c;
        logic s;
        logic z;
        logic v;
    } gr_flags_t;

    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dst;
        logic [OP_W-1:0]  op;
    } gr_ctrl_t;

    function automatic logic gr_is_arith(input logic [OP_W-1:0] op);
        return (op == OP_INC) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_DEC);
    endfunction

    function automatic logic gr_is_logic(input logic [OP_W-1:0] op);
        return (op == OP_PASS) || (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
               (op == OP_NOT) || (op == OP_SHR) || (op == OP_SHL);
    endfunction

endpackage

// File: rtl/gr_src_mux.sv
module gr_src_mux #(
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 3,
    parameter int NUM_REGS = (1 << SEL_W) - 1
) (
    input  logic [NUM_REGS:1][DATA_W-1:0] regs_i,
    input  logic [DATA_W-1:0]             ext_i,
    input  logic [SEL_W-1:0]              sel_i,
    output logic [DATA_W-1:0]             bus_o
);

    always_comb begin
        bus_o = ext_i;
        for (int k = 1; k <= NUM_REGS; k++) begin
            if (sel_i == SEL_W'(k)) begin
                bus_o = regs_i[k];
            end
        end
    end

endmodule

// File: rtl/gr_alu.sv
module gr_alu
    import gr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [OP_W-1:0]   op_i,
    output logic [DATA_W-1:0] res_o,
    output gr_flags_t         flags_o,
    output gr_cls_e           cls_o
);

    localparam int LOW_W = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              cin;
    logic [DATA_W:0]   full_sum;
    logic [DATA_W-1:0] low_sum;
    logic              carry_msb_in;
    logic              carry_msb_out;

    always_comb begin
        b_eff = '0;
        cin   = 1'b0;
        case (op_i)
            OP_INC:  begin b_eff = '0;    cin = 1'b1; end
            OP_ADD:  begin b_eff = b_i;   cin = 1'b0; end
            OP_SUB:  begin b_eff = ~b_i;  cin = 1'b1; end
            OP_DEC:  begin b_eff = '1;    cin = 1'b0; end
            default: begin b_eff = '0;    cin = 1'b0; end
        endcase
    end

    assign full_sum      = {1'b0, a_i} + {1'b0, b_eff} + (DATA_W+1)'(cin);
    assign low_sum       = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + DATA_W'(cin);
    assign carry_msb_in  = low_sum[LOW_W];
    assign carry_msb_out = full_sum[DATA_W];

    always_comb begin
        res_o = '0;
        cls_o = CLS_LOGIC;
        case (op_i)
            OP_INC, OP_ADD, OP_SUB, OP_DEC: begin
                res_o = full_sum[DATA_W-1:0];
                cls_o = CLS_ARITH;
            end
            OP_PASS: res_o = a_i;
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOT:  res_o = ~a_i;
            OP_SHR:  res_o = {1'b0, a_i[DATA_W-1:1]};
            OP_SHL:  res_o = {a_i[DATA_W-2:0], 1'b0};
            default: begin
                res_o = '0;
                cls_o = CLS_NONE;
            end
        endcase
    end

    always_comb begin
        flags_o.s = res_o[DATA_W-1];
        flags_o.z = (res_o == '0);
        if (cls_o == CLS_ARITH) begin
            flags_o.c = carry_msb_out;
            flags_o.v = carry_msb_in ^ carry_msb_out;
        end else begin
            flags_o.c = 1'b0;
            flags_o.v = 1'b0;
        end
    end

endmodule

// File: rtl/gr_regfile.sv
module gr_regfile #(
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 3,
    parameter int NUM_REGS = (1 << SEL_W) - 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SEL_W-1:0]              wr_sel_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    output logic [NUM_REGS:1][DATA_W-1:0] regs_o
);

    logic [NUM_REGS:1]             we;
    logic [NUM_REGS:1][DATA_W-1:0] regs_d;
    logic [NUM_REGS:1][DATA_W-1:0] regs_q;

    for (genvar k = 1; k <= NUM_REGS; k++) begin : g_dec
        assign we[k] = (wr_sel_i == SEL_W'(k));

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
            we[k] |=> (regs_q[k] == $past(wr_data_i))); // R3
    end

    always_comb begin
        regs_d = regs_q;
        for (int k = 1; k <= NUM_REGS; k++) begin
            if (we[k]) begin
                regs_d[k] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

    AST_NO_WRITE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_sel_i == '0) |=> $stable(regs_q)); // R4

    AST_REGS_CLEARED: assert property (@(posedge clk)
        rst |=> (regs_q == '0)); // R12

endmodule

// File: rtl/gr_datapath.sv
module gr_datapath
    import gr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [3*SEL_W+OP_W-1:0]     ctrl_i,
    input  logic [DATA_W-1:0]           ext_i,
    output logic [DATA_W-1:0]           result_o,
    output logic [3:0]                  flags_o
);

    localparam int NUM_REGS = (1 << SEL_W) - 1;

    typedef struct packed {
        gr_flags_t flags;
    } state_t;

    gr_ctrl_t                      ctrl;
    logic [NUM_REGS:1][DATA_W-1:0] regs;
    logic [DATA_W-1:0]             bus_a;
    logic [DATA_W-1:0]             bus_b;
    logic [DATA_W-1:0]             alu_res;
    gr_flags_t                     alu_flags;
    gr_cls_e                       alu_cls;
    state_t                        st_d;
    state_t                        st_q;

    assign ctrl = gr_ctrl_t'(ctrl_i);

    gr_src_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS)) u_mux_a (
        .regs_i (regs),
        .ext_i  (ext_i),
        .sel_i  (ctrl.src_a),
        .bus_o  (bus_a)
    );

    gr_src_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS)) u_mux_b (
        .regs_i (regs),
        .ext_i  (ext_i),
        .sel_i  (ctrl.src_b),
        .bus_o  (bus_b)
    );

    gr_alu #(.DATA_W(DATA_W)) u_alu (
        .a_i     (bus_a),
        .b_i     (bus_b),
        .op_i    (ctrl.op),
        .res_o   (alu_res),
        .flags_o (alu_flags),
        .cls_o   (alu_cls)
    );

    gr_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_sel_i  (ctrl.dst),
        .wr_data_i (alu_res),
        .regs_o    (regs)
    );

    always_comb begin
        st_d = st_q;
        if (alu_cls != CLS_NONE) begin
            st_d.flags = alu_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = alu_res;
    assign flags_o  = st_q.flags;

    AST_LOGIC_CLEARS_CV: assert property (@(posedge clk) disable iff (rst)
        gr_is_logic(ctrl_i[OP_W-1:0]) |=> (!flags_o[3] && !flags_o[0])); // R11

    AST_UNUSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!gr_is_logic(ctrl_i[OP_W-1:0]) && !gr_is_arith(ctrl_i[OP_W-1:0]))
        |=> $stable(flags_o)); // R9

    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
        gr_is_arith(ctrl_i[OP_W-1:0]) |=> (flags_o[1] == ($past(result_o) == '0))); // R10

    AST_FLAGS_CLEARED: assert property (@(posedge clk)
        rst |=> (flags_o == 4'b0000)); // R12

endmodule

// File: tb/gr_datapath_bench.sv
`timescale 1ns/1ps
module gr_datapath_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] ctrl = 14'b000_000_000_11111;
    logic [7:0]  ext = 8'h00;
    logic [7:0]  result;
    logic [3:0]  flags;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        logic [7:0] res;
        logic [3:0] flg;
        int         req;
    } item_t;

    item_t      sb[$];
    logic [7:0] m_reg [0:7];
    logic [3:0] m_flg;

    always #2.5 clk = ~clk;

    gr_datapath u_gr_datapath (
        .clk      (clk),
        .rst      (rst),
        .ctrl_i   (ctrl),
        .ext_i    (ext),
        .result_o (result),
        .flags_o  (flags)
    );

    task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference taken from the requirement text (R6..R11)
    task automatic model(input logic [7:0] a, input logic [7:0] b, input logic [4:0] op,
                         output logic [7:0] r, output logic [3:0] f, input logic [3:0] fin);
        logic [8:0] s9;
        logic [7:0] lo;
        logic [7:0] be;
        logic       ci;
        logic       arith;
        logic       logic_op;
        arith = 1'b1; logic_op = 1'b0; be = 8'h00; ci = 1'b0; r = 8'h00;
        case (op)
            5'b00001: begin be = 8'h00; ci = 1'b1; end
            5'b00010: begin be = b;     ci = 1'b0; end
            5'b00101: begin be = ~b;    ci = 1'b1; end
            5'b00110: begin be = 8'hFF; ci = 1'b0; end
            default:  arith = 1'b0;
        endcase
        s9 = {1'b0, a} + {1'b0, be} + {8'h00, ci};
        lo = {1'b0, a[6:0]} + {1'b0, be[6:0]} + {7'h00, ci};
        if (arith) r = s9[7:0];
        case (op)
            5'b00000: begin r = a;              logic_op = 1'b1; end
            5'b01000: begin r = a & b;          logic_op = 1'b1; end
            5'b01010: begin r = a | b;          logic_op = 1'b1; end
            5'b01100: begin r = a ^ b;          logic_op = 1'b1; end
            5'b01110: begin r = ~a;             logic_op = 1'b1; end
            5'b10000: begin r = {1'b0, a[7:1]}; logic_op = 1'b1; end
            5'b11000: begin r = {a[6:0], 1'b0}; logic_op = 1'b1; end
            default: ;
        endcase
        if (arith)         f = {s9[8], r[7], (r == 8'h00), lo[7] ^ s9[8]};
        else if (logic_op) f = {1'b0, r[7], (r == 8'h00), 1'b0};
        else               f = fin;
    endtask

    // Driver: applies one control word at the falling edge, queues expectation
    task automatic op(input logic [2:0] sa, input logic [2:0] sb_, input logic [2:0] sd,
                      input logic [4:0] opr, input logic [7:0] x, input int req);
        logic [7:0] a;
        logic [7:0] b;
        item_t      it;
        @(negedge clk);
        a = (sa == 3'd0) ? x : m_reg[sa];
        b = (sb_ == 3'd0) ? x : m_reg[sb_];
        model(a, b, opr, it.res, it.flg, m_flg);
        it.req = req;
        sb.push_back(it);
        m_flg = it.flg;
        if (sd != 3'd0) m_reg[sd] = it.res;
        ctrl = {sa, sb_, sd, opr};   // R1 field layout
        ext  = x;
    endtask

    task automatic idle();
        @(negedge clk);
        ctrl = 14'b000_000_000_11111;
        ext  = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        ctrl = 14'b000_000_000_11111;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) m_reg[k] = 8'h00;
        m_flg = 4'h0;
    endtask

    // Monitor: result before the edge (R5), flags after it
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check(it.req, "result", result, it.res);
                @(posedge clk);
                #1;
                check(it.req, "flags", {4'h0, flags}, {4'h0, it.flg});
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) m_reg[k] = 8'h00;
        m_flg = 4'h0;
        do_reset();
        #1;
        check(12, "flags after reset", {4'h0, flags}, 8'h00);       // R12
        for (int k = 1; k < 8; k++) op(3'(k), 3'd0, 3'd0, 5'b00000, 8'h00, 12); // R12 regs zero

        op(3'd0, 3'd0, 3'd2, 5'b00000, 8'h12, 2);   // R2 ext on A, R3 write
        op(3'd0, 3'd0, 3'd3, 5'b00000, 8'h34, 3);   // R3
        op(3'd2, 3'd3, 3'd1, 5'b00010, 8'hAA, 5);   // R5 R6 add example, same-cycle result
        op(3'd1, 3'd0, 3'd0, 5'b00000, 8'h00, 3);   // R3 R1 holds 46
        op(3'd2, 3'd0, 3'd0, 5'b00000, 8'h00, 3);   // R3 R2 untouched

        op(3'd0, 3'd0, 3'd4, 5'b00000, 8'hF0, 2);
        op(3'd0, 3'd0, 3'd5, 5'b00000, 8'h14, 2);
        op(3'd4, 3'd5, 3'd6, 5'b00101, 8'h00, 10);  // R10 F0-14=DC C1 S1 Z0 V0
        op(3'd6, 3'd0, 3'd0, 5'b00000, 8'h00, 3);

        op(3'd0, 3'd0, 3'd7, 5'b00000, 8'h7F, 2);
        op(3'd7, 3'd0, 3'd0, 5'b00010, 8'h01, 4);   // R4 R10 80 with V, no write
        op(3'd7, 3'd0, 3'd0, 5'b00000, 8'h00, 4);   // R4 R7 still 7F
        op(3'd0, 3'd0, 3'd0, 5'b00010, 8'h80, 10);  // R10 80+80: C1 Z1 V1
        op(3'd2, 3'd2, 3'd0, 5'b00101, 8'h00, 10);  // R10 x-x: Z1 C1
        op(3'd0, 3'd0, 3'd0, 5'b00001, 8'hFF, 6);   // R6 inc FF wraps
        op(3'd4, 3'd5, 3'd0, 5'b01000, 8'h00, 11);  // R11 AND clears C
        op(3'd0, 3'd0, 3'd0, 5'b00110, 8'h00, 6);   // R6 dec 00 -> FF
        op(3'd4, 3'd5, 3'd1, 5'b01010, 8'h00, 7);   // R7 OR
        op(3'd3, 3'd5, 3'd0, 5'b01100, 8'h00, 1);   // R1 distinct fields, XOR
        op(3'd4, 3'd4, 3'd0, 5'b01100, 8'h00, 7);   // R7 XOR to zero
        op(3'd5, 3'd0, 3'd0, 5'b01110, 8'h00, 7);   // R7 NOT
        op(3'd0, 3'd0, 3'd0, 5'b00010, 8'h80, 10);  // sets C and V again
        op(3'd4, 3'd0, 3'd0, 5'b10000, 8'h00, 8);   // R8 shift right, R11 clears C V
        op(3'd4, 3'd0, 3'd0, 5'b11000, 8'h00, 8);   // R8 shift left
        op(3'd0, 3'd0, 3'd0, 5'b11000, 8'h81, 8);   // R8 msb dropped
        op(3'd0, 3'd0, 3'd0, 5'b00001, 8'hFF, 6);   // flags C1 Z1
        op(3'd4, 3'd5, 3'd1, 5'b00011, 8'h00, 9);   // R9 unused code: zero, flags held
        op(3'd0, 3'd0, 3'd0, 5'b10101, 8'h55, 9);   // R9
        op(3'd1, 3'd0, 3'd0, 5'b00000, 8'h00, 9);   // R9 zero was stored

        op(3'd0, 3'd0, 3'd6, 5'b00000, 8'h99, 3);
        idle();
        do_reset();                                 // R12 mid-run
        #1;
        check(12, "flags after second reset", {4'h0, flags}, 8'h00);
        op(3'd6, 3'd7, 3'd0, 5'b00010, 8'h00, 12);  // R12 regs cleared
        idle();
        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule